// File: doc/BRIEF.md
# Quadrature Encoder Counter with Index

This block turns the A and B lines of an incremental encoder into a signed position count. It can also take a plain up/down pulse input, where A carries the pulses and B gives the direction. Each of the four input lines (A, B, Index and the mask pin) first passes through a two-flop synchronizer. It then passes through a digital glitch filter, whose hold length is chosen at run time from a long setting and a short setting.

Two counters are kept. The working count can be forced to zero by a level-sensitive clear input. It is also zeroed by an index event when the index arm is set. The raw count follows every step and is never cleared. An index event is a chosen edge of the filtered Index line. A mask pin with its own selectable polarity can further qualify it. When an armed event occurs, the arm drops by itself, so software sees that the zeroing has taken place. In quadrature mode, a step in which A and B change together is ignored and sets a sticky error flag.

Top module: `quad_index_counter`

## Requirements
- R1: A change on any input line is accepted only after the synchronized line has held the new value for 15 consecutive clocks when `filterLong` is 1, or for 3 when it is 0. A shorter pulse has no effect on any output.
- R2: In quadrature mode (`modeUpDown`=0), every accepted single-line change along the sequence {A,B} = 00, 10, 11, 01, 00 adds one to `count` and `rawCount`. One full cycle therefore adds 4.
- R3: In quadrature mode, every accepted single-line change along the reverse sequence {A,B} = 00, 01, 11, 10, 00 subtracts one from `count` and `rawCount`.
- R4: In quadrature mode, when A and B are accepted as changing in the same cycle, `count` and `rawCount` stay unchanged and `quadError` goes to 1. `quadError` then stays 1 until `rstN` is asserted.
- R5: In up/down mode (`modeUpDown`=1), only a rising edge of A changes the counts. The change is +1 when B is low and -1 when B is high. Falling edges of A and any change of B have no effect, and `quadError` does not change.
- R6: The index event is the rising edge of the filtered Index line when `idxInvert`=1, and its falling edge when `idxInvert`=0. The opposite edge is not an event.
- R7: With `maskEnable`=1, an index edge is an event only while the filtered mask pin is high (`maskInvert`=0) or low (`maskInvert`=1). With `maskEnable`=0, the mask pin is ignored.
- R8: A one-cycle pulse on `idxArmReq` sets `idxArmed`. While `idxArmed` is 1, an index event sets `count` to zero and clears `idxArmed` on the same clock edge. An index event with `idxArmed`=0 leaves `count` unchanged.
- R9: While `clearCount` is 1, `count` is held at zero. After it is released, counting resumes from zero. The block never releases `clearCount` itself.
- R10: `rawCount` is not affected by index events or by `clearCount`.
- R11: After `rstN` is asserted low, `count`, `rawCount`, `idxArmed` and `quadError` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinA | input | 1 | Encoder phase A, or pulse input in up/down mode |
| pinB | input | 1 | Encoder phase B, or direction in up/down mode |
| pinIdx | input | 1 | Index line |
| pinMask | input | 1 | Index qualifying pin |
| modeUpDown | input | 1 | 0 = quadrature, 1 = up/down |
| filterLong | input | 1 | 1 = 15-clock filter, 0 = 3-clock filter |
| idxArmReq | input | 1 | Pulse that arms the index zeroing |
| idxInvert | input | 1 | 1 = rising index edge is the event, 0 = falling |
| maskEnable | input | 1 | Enables mask-pin qualification |
| maskInvert | input | 1 | 1 = mask pin must be low to qualify |
| clearCount | input | 1 | Holds `count` at zero while high |
| count | output | CNT_W | Signed working count |
| rawCount | output | CNT_W | Raw count, never cleared |
| idxArmed | output | 1 | Index arm, cleared by an armed event |
| quadError | output | 1 | Sticky illegal-transition flag |

## Verification
The quadrature decoder is driven with directed forward and reverse Gray walks, then with a long seeded random walk that reverses direction often and switches filter length between steps. This separates a sign error from a missed count and from a decoder tied to a single direction. A simultaneous A/B flip separates a correct illegal-step rejection from one that counts. In up/down mode, the filter gets pulses exactly one clock shorter than the hold length and pulses exactly at it, for both settings. An off-by-one in the hold counter then shows up as a missing or extra count. Index runs pair each event edge with its opposite edge and each mask polarity with its disqualifying level. Every event-producing case also checks that `rawCount` stays untouched.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int NUM_LINES = 4;   // A, B, Index, mask pin
  localparam int LINE_A    = 0;
  localparam int LINE_B    = 1;
  localparam int LINE_IDX  = 2;
  localparam int LINE_MASK = 3;

  typedef struct packed {
    logic up;       // count one step forward
    logic down;     // count one step backward
    logic idxHit;   // qualified index edge
    logic badStep;  // A and B changed together in quadrature mode
  } qencStrobe_t;
endpackage

// File: rtl/qenc_line_filter.sv
module qenc_line_filter #(
  parameter int LONG_HOLD  = 15,
  parameter int SHORT_HOLD = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic useLong,
  output logic lineOut
);
  localparam int CW = $clog2(LONG_HOLD + 1);

  logic syncA, syncB;
  logic [CW-1:0] holdCnt;
  logic [CW-1:0] holdLimit;

  assign holdLimit = useLong ? CW'(LONG_HOLD - 1) : CW'(SHORT_HOLD - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // Saturating hold counter: reloads whenever the input agrees with the output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      lineOut <= 1'b0;
    end else if (syncB == lineOut) begin
      holdCnt <= '0;
    end else if (holdCnt >= holdLimit) begin
      lineOut <= syncB;
      holdCnt <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int LONG_HOLD  = 15,
  parameter int SHORT_HOLD = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinA,
  input  logic        pinB,
  input  logic        pinIdx,
  input  logic        pinMask,
  input  logic        modeUpDown,
  input  logic        filterLong,
  input  logic        idxInvert,
  input  logic        maskEnable,
  input  logic        maskInvert,
  output qencStrobe_t strobe
);
  logic [NUM_LINES-1:0] pinVec;
  logic [NUM_LINES-1:0] fltNow;
  logic [NUM_LINES-1:0] fltPrev;

  assign pinVec = {pinMask, pinIdx, pinB, pinA};

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    qenc_line_filter #(
      .LONG_HOLD (LONG_HOLD),
      .SHORT_HOLD(SHORT_HOLD)
    ) uFilt (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinVec[g]),
      .useLong(filterLong),
      .lineOut(fltNow[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fltPrev <= '0;
    else       fltPrev <= fltNow;
  end

  logic aNow, bNow, aOld, bOld, iNow, iOld, mNow;
  logic edgeA, edgeB, riseA, idxEdge, maskOk;

  assign aNow = fltNow[LINE_A];
  assign bNow = fltNow[LINE_B];
  assign iNow = fltNow[LINE_IDX];
  assign mNow = fltNow[LINE_MASK];
  assign aOld = fltPrev[LINE_A];
  assign bOld = fltPrev[LINE_B];
  assign iOld = fltPrev[LINE_IDX];

  assign edgeA   = aNow ^ aOld;
  assign edgeB   = bNow ^ bOld;
  assign riseA   = aNow & ~aOld;
  assign idxEdge = idxInvert ? (iNow & ~iOld) : (~iNow & iOld);
  assign maskOk  = ~maskEnable | (mNow ^ maskInvert);

  always_comb begin
    strobe = '0;
    if (modeUpDown) begin
      strobe.up   = riseA & ~bNow;
      strobe.down = riseA & bNow;
    end else begin
      strobe.badStep = edgeA & edgeB;
      // one line moved: forward when new A differs from previous B
      strobe.up   = (edgeA ^ edgeB) & (aNow ^ bOld);
      strobe.down = (edgeA ^ edgeB) & ~(aNow ^ bOld);
    end
    strobe.idxHit = idxEdge & maskOk;
  end
endmodule

// File: rtl/qenc_dpath.sv
module qenc_dpath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  qencStrobe_t      strobe,
  input  logic             idxArmReq,
  input  logic             clearCount,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rawCount,
  output logic             idxArmed,
  output logic             quadError
);
  logic zeroByIdx;
  assign zeroByIdx = idxArmed & strobe.idxHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      rawCount  <= '0;
      idxArmed  <= 1'b0;
      quadError <= 1'b0;
    end else begin
      if (strobe.up)        rawCount <= rawCount + 1'b1;
      else if (strobe.down) rawCount <= rawCount - 1'b1;

      if (clearCount || zeroByIdx) count <= '0;
      else if (strobe.up)          count <= count + 1'b1;
      else if (strobe.down)        count <= count - 1'b1;

      idxArmed  <= (idxArmed & ~zeroByIdx) | idxArmReq;
      quadError <= quadError | strobe.badStep;
    end
  end
endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LONG_HOLD  = 15,
  parameter int SHORT_HOLD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinA,
  input  logic             pinB,
  input  logic             pinIdx,
  input  logic             pinMask,
  input  logic             modeUpDown,
  input  logic             filterLong,
  input  logic             idxArmReq,
  input  logic             idxInvert,
  input  logic             maskEnable,
  input  logic             maskInvert,
  input  logic             clearCount,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rawCount,
  output logic             idxArmed,
  output logic             quadError
);
  qencStrobe_t strobe;

  qenc_ctrl #(
    .LONG_HOLD (LONG_HOLD),
    .SHORT_HOLD(SHORT_HOLD)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pinA      (pinA),
    .pinB      (pinB),
    .pinIdx    (pinIdx),
    .pinMask   (pinMask),
    .modeUpDown(modeUpDown),
    .filterLong(filterLong),
    .idxInvert (idxInvert),
    .maskEnable(maskEnable),
    .maskInvert(maskInvert),
    .strobe    (strobe)
  );

  qenc_dpath #(
    .CNT_W(CNT_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .idxArmReq (idxArmReq),
    .clearCount(clearCount),
    .count     (count),
    .rawCount  (rawCount),
    .idxArmed  (idxArmed),
    .quadError (quadError)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeUpDown,
  input logic             clearCount,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rawCount,
  input logic             idxArmed,
  input logic             quadError
);
  // count moves by one step, or to zero
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) && (count != '0) |->
      ((count - $past(count)) == CNT_W'(1)) || (($past(count) - count) == CNT_W'(1)));

  assert_raw_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rawCount != $past(rawCount)) |->
      ((rawCount - $past(rawCount)) == CNT_W'(1)) || (($past(rawCount) - rawCount) == CNT_W'(1)));

  assert_error_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(quadError) |-> quadError);

  assert_updown_no_error_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeUpDown) |-> $stable(quadError));

  assert_arm_drop_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idxArmed) |-> (count == '0));

  assert_clear_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearCount) |-> (count == '0));
endmodule

bind quad_index_counter qenc_checker #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .modeUpDown(modeUpDown),
  .clearCount(clearCount),
  .count     (count),
  .rawCount  (rawCount),
  .idxArmed  (idxArmed),
  .quadError (quadError)
);

// File: tb/sim_quad_index_counter.sv
module sim_quad_index_counter;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinA = 0, pinB = 0, pinIdx = 0, pinMask = 0;
  logic modeUpDown = 0, filterLong = 1, idxArmReq = 0;
  logic idxInvert = 1, maskEnable = 0, maskInvert = 0, clearCount = 0;
  logic [31:0] count, rawCount;
  logic idxArmed, quadError;

  int checks = 0;
  int fails = 0;
  int expCount = 0;
  int expRaw = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_index_counter u0 (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .pinIdx(pinIdx),
    .pinMask(pinMask), .modeUpDown(modeUpDown), .filterLong(filterLong),
    .idxArmReq(idxArmReq), .idxInvert(idxInvert), .maskEnable(maskEnable),
    .maskInvert(maskInvert), .clearCount(clearCount), .count(count),
    .rawCount(rawCount), .idxArmed(idxArmed), .quadError(quadError)
  );

  function automatic int phaseOf(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int quadDelta(input logic pa, pb, na, nb);
    if ((pa != na) && (pb != nb)) return 0;
    if ((pa == na) && (pb == nb)) return 0;
    return (((phaseOf(na, nb) - phaseOf(pa, pb) + 4) % 4) == 1) ? 1 : -1;
  endfunction

  function automatic int udDelta(input logic pa, na, b);
    if (!pa && na) return b ? -1 : 1;
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic driveAB(input logic a, input logic b);
    int d;
    if (modeUpDown) d = udDelta(pinA, a, b);
    else            d = quadDelta(pinA, pinB, a, b);
    pinA = a;
    pinB = b;
    waitCycles(SETTLE);
    expRaw += d;
    if (!clearCount) expCount += d;
    else             expCount = 0;
  endtask

  task automatic quadStep(input bit fwd);
    int p;
    logic [1:0] nxt;
    p = (phaseOf(pinA, pinB) + (fwd ? 1 : 3)) % 4;
    case (p)
      0: nxt = 2'b00;
      1: nxt = 2'b10;
      2: nxt = 2'b11;
      default: nxt = 2'b01;
    endcase
    driveAB(nxt[1], nxt[0]);
  endtask

  task automatic armIndex();
    idxArmReq = 1;
    @(posedge clk);
    @(negedge clk);
    idxArmReq = 0;
  endtask

  task automatic setIdx(input logic v);
    pinIdx = v;
    waitCycles(SETTLE);
  endtask

  task automatic pulseA(input int len);
    pinA = 1;
    repeat (len) @(posedge clk);
    @(negedge clk);
    pinA = 0;
    waitCycles(SETTLE);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    waitCycles(5);
    check("R11 count", count, 0);
    check("R11 rawCount", rawCount, 0);
    check("R11 idxArmed", {31'd0, idxArmed}, 0);
    check("R11 quadError", {31'd0, quadError}, 0);
    rstN = 1;
    waitCycles(2);

    // R2 forward walk, two full cycles
    for (int i = 0; i < 8; i++) quadStep(1);
    check("R2 forward count", count, 32'(expCount));
    check("R2 forward count value 8", count, 8);
    // R3 reverse
    for (int i = 0; i < 5; i++) quadStep(0);
    check("R3 reverse count", count, 3);
    check("R3 reverse raw", rawCount, 32'(expRaw));

    // random walk across both filter lengths (R2, R3)
    for (int i = 0; i < 120; i++) begin
      filterLong = 1'($urandom_range(0, 1));
      quadStep(1'($urandom_range(0, 1)));
      if (i % 10 == 9) begin
        check("R2 R3 random count", count, 32'(expCount));
        check("R2 R3 random raw", rawCount, 32'(expRaw));
      end
    end
    filterLong = 1;
    check("R4 no error before", {31'd0, quadError}, 0);

    // R4 illegal double flip
    driveAB(~pinA, ~pinB);
    check("R4 illegal count", count, 32'(expCount));
    check("R4 illegal raw", rawCount, 32'(expRaw));
    check("R4 error set", {31'd0, quadError}, 1);
    quadStep(1);
    check("R4 error sticky", {31'd0, quadError}, 1);
    check("R4 count after", count, 32'(expCount));

    // index polarity, arm self-clear (R6, R8, R10)
    quadStep(1);
    idxInvert = 1;
    armIndex();
    check("R8 armed", {31'd0, idxArmed}, 1);
    setIdx(1);
    expCount = 0;
    check("R8 R6 rising event zero", count, 0);
    check("R8 arm cleared", {31'd0, idxArmed}, 0);
    check("R10 raw kept at index", rawCount, 32'(expRaw));
    quadStep(1); quadStep(1);
    armIndex();
    setIdx(0);
    check("R6 falling not event count", count, 2);
    check("R6 falling not event arm", {31'd0, idxArmed}, 1);
    idxInvert = 0;
    setIdx(1);
    check("R6 rising not event inv0", {31'd0, idxArmed}, 1);
    setIdx(0);
    expCount = 0;
    check("R6 falling event inv0", count, 0);
    quadStep(1);
    setIdx(1);
    setIdx(0);
    check("R8 unarmed event no effect", count, 1);

    // mask qualification (R7)
    setIdx(1);
    maskEnable = 1; maskInvert = 0; pinMask = 0;
    waitCycles(SETTLE);
    armIndex();
    setIdx(0);
    check("R7 mask low blocks", count, 1);
    check("R7 mask low arm kept", {31'd0, idxArmed}, 1);
    setIdx(1);
    pinMask = 1;
    waitCycles(SETTLE);
    setIdx(0);
    expCount = 0;
    check("R7 mask high passes", count, 0);
    maskInvert = 1;
    quadStep(1);
    armIndex();
    setIdx(1);
    setIdx(0);
    check("R7 inverted mask high blocks", count, 1);
    pinMask = 0;
    waitCycles(SETTLE);
    setIdx(1);
    setIdx(0);
    expCount = 0;
    check("R7 inverted mask low passes", count, 0);
    check("R10 raw kept after mask", rawCount, 32'(expRaw));
    maskEnable = 0;

    // R9 clear hold, R10 raw continues
    clearCount = 1;
    for (int i = 0; i < 3; i++) quadStep(1);
    check("R9 count held", count, 0);
    check("R10 raw runs under clear", rawCount, 32'(expRaw));
    clearCount = 0;
    quadStep(1);
    check("R9 resume from zero", count, 1);

    // R5 up/down mode
    modeUpDown = 1;
    driveAB(0, 0);
    check("R5 setup count", count, 32'(expCount));
    driveAB(1, 0);
    check("R5 rise A B low up", count, 32'(expCount));
    driveAB(0, 0);
    driveAB(0, 1);
    check("R5 fall A and B change none", count, 32'(expCount));
    driveAB(1, 1);
    check("R5 rise A B high down", count, 32'(expCount));
    driveAB(0, 1);
    driveAB(0, 0);
    check("R5 raw follows", rawCount, 32'(expRaw));
    check("R5 error unchanged", {31'd0, quadError}, 1);

    // R1 filter boundaries, measured in up/down mode with B low
    begin
      int base;
      base = expCount;
      filterLong = 1;
      pulseA(14);
      check("R1 long 14 rejected", count, 32'(base));
      pulseA(15);
      base += 1;
      check("R1 long 15 accepted", count, 32'(base));
      filterLong = 0;
      pulseA(2);
      check("R1 short 2 rejected", count, 32'(base));
      pulseA(3);
      base += 1;
      check("R1 short 3 accepted", count, 32'(base));
      check("R1 raw", rawCount, 32'(expRaw + 2));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule